// File: doc/BRIEF.md
# Byte-Bus Sixteen-Bit Event Timer

This block is a sixteen-bit up-counter that software reaches through an eight-bit register port. It counts either a one-cycle instruction-rate enable or the rising edges of an external clock pin. The pin can be taken through a full two-stage synchroniser or through a single sampling stage that has one cycle less latency. A divide-by-1/2/4/8 prescaler sits in front of the counter. A run bit gates counting. When the counter rolls over from FFFFh to 0000h, a sticky overflow flag is raised.

Software sees two byte views of the counter. In paired (sixteen-bit) access mode, reading the low byte copies the high byte into a read holding register, so the high byte read that follows is coherent with that low byte. In the same mode, writing the high byte only fills a write holding register, and both bytes land in the counter together on the low-byte write. In direct mode, each byte access goes straight to the live counter. The snapshot works in the same way for every clock source.

The edge detector on the pin is a two-state machine. State `EDGE_LOW` means the sampled pin was last seen low. Transition `EDGE_LOW -> EDGE_HIGH` happens when the sample reads 1, and that transition emits one count tick. Transition `EDGE_HIGH -> EDGE_LOW` happens when the sample reads 0. Both states hold otherwise. Reset enters `EDGE_LOW`.

Top module: `bytebus_timer`

## Requirements
- R1: After reset, the counter, both holding registers and the control register (address 2) all read 0, and `irq_flag` is 0.
- R2: With control bit 0 (run) set, bit 1 (source) clear and prescaler select 00, every clock edge at which `cyc_tick` is high adds one to the counter at that edge.
- R3: Control bits [4:3] select division of the tick stream by 1, 2, 4 or 8 (00, 01, 10, 11). The prescaler is cleared by any write that changes the counter, so after such a write the counter advances on the 1st, 2nd, 4th or 8th tick.
- R4: While the run bit is 0, ticks and pin edges leave the counter unchanged.
- R5: With bit 1 set and bit 2 (sync) clear, a rising edge on `ext_clk` increments the counter at the second clock edge that sees the pin high. With bit 2 set, it does so at the third such edge. Each rising edge counts once.
- R6: With bit 6 (paired access) set, a read of address 0 (low byte) copies the live high byte into the read holding register. Reads of address 1 (high byte) then return that copy, even after the counter has moved on.
- R7: With bit 6 clear, a read of address 1 returns the live counter high byte.
- R8: The low-read snapshot of R6 behaves the same when counting the external pin in both synchronised and unsynchronised mode.
- R9: With bit 6 set, a write to address 1 leaves the counter unchanged. The next write to address 0 loads the counter with {held high byte, written low byte}.
- R10: With bit 6 clear, a write to address 0 or 1 replaces only that byte of the counter at once.
- R11: A wrap from FFFFh to 0000h sets control bit 7 and `irq_flag` at that edge. The flag stays set until software writes bit 7 as 0. If a wrap and a clearing write fall in the same cycle, the flag ends up set.
- R12: A counter write and an increment in the same cycle leave the written value, with no increment applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_tick | input | 1 | Instruction-rate count enable (internal source) |
| ext_clk | input | 1 | External count clock pin |
| reg_addr | input | 2 | Register select: 0 low byte, 1 high byte, 2 control |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the high-byte snapshot) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register, valid in the same cycle |
| irq_flag | output | 1 | Overflow interrupt flag (control bit 7) |

## Verification
Read data is combinational, so the bench samples it 1 ns after a falling edge, in the same cycle as the strobe. The effects of writes and ticks are looked for after the next rising edge has passed. An internal tick shows up one edge after it is driven. A pin edge shows up two edges after it in unsynchronised mode and three in synchronised mode. The bench therefore samples one cycle before and at the expected edge, and checks that the count has not moved early. An overflow flag is checked in the cycle right after the wrapping edge. The flag-clear race and the write-versus-tick race are driven in one shared cycle so that the required priority is what the outputs show.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    localparam logic [1:0] ADDR_LO   = 2'd0;
    localparam logic [1:0] ADDR_HI   = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    typedef struct packed {
        logic       ovf;     // bit 7
        logic       paired;  // bit 6
        logic       spare;   // bit 5
        logic [1:0] div_sel; // bits 4:3
        logic       sync;    // bit 2
        logic       src_ext; // bit 1
        logic       run;     // bit 0
    } ctrl_t;

    typedef enum logic [0:0] {
        EDGE_LOW  = 1'b0,
        EDGE_HIGH = 1'b1
    } edge_state_t;

endpackage

// File: rtl/tmr_edge_fsm.sv
module tmr_edge_fsm
    import tmr_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic use_sync,
    output logic edge_tick
);
    logic [SYNC_DEPTH-1:0] stage_q;
    logic                  sample;
    edge_state_t           state_q, state_d;

    generate
        for (genvar i = 0; i < SYNC_DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= 1'b0;
                    else        stage_q[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[i] <= 1'b0;
                    else        stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign sample = use_sync ? stage_q[SYNC_DEPTH-1] : stage_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EDGE_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        edge_tick = 1'b0;
        unique case (state_q)
            EDGE_LOW: begin
                if (sample) begin
                    state_d   = EDGE_HIGH;
                    edge_tick = 1'b1;
                end
            end
            EDGE_HIGH: begin
                if (!sample) state_d = EDGE_LOW;
            end
            default: state_d = EDGE_LOW;
        endcase
    end

    // R5
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_tick |=> !edge_tick);

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    output logic             tick_out
);
    localparam int PS_W = (1 << SEL_W) - 1;

    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] mask;

    assign mask     = PS_W'((1 << sel) - 1);
    assign tick_out = tick_in && ((ps_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ps_q <= '0;
        else if (clear)   ps_q <= '0;
        else if (tick_in) ps_q <= ps_q + PS_W'(1);
    end

    // R3
    div1_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0 && tick_in) |-> tick_out);

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              inc_en,
    output logic [BYTE_W-1:0] bus_rdata,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              load_o
);
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] hi_wbuf_q;
    logic [BYTE_W-1:0] hi_rbuf_q;
    ctrl_t             ctrl_q;
    logic              lo_wr, hi_wr, ctrl_wr, lo_rd, wrap;

    assign lo_wr   = bus_wr && (bus_addr == ADDR_LO);
    assign hi_wr   = bus_wr && (bus_addr == ADDR_HI);
    assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
    assign lo_rd   = bus_rd && (bus_addr == ADDR_LO);
    assign load_o  = lo_wr || (hi_wr && !ctrl_q.paired);
    assign wrap    = inc_en && !load_o && (cnt_q == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (lo_wr) begin
            cnt_q <= ctrl_q.paired ? {hi_wbuf_q, bus_wdata}
                                   : {cnt_q[CNT_W-1:BYTE_W], bus_wdata};
        end else if (hi_wr && !ctrl_q.paired) begin
            cnt_q <= {bus_wdata, cnt_q[BYTE_W-1:0]};
        end else if (inc_en) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       hi_wbuf_q <= '0;
        else if (hi_wr && ctrl_q.paired)  hi_wbuf_q <= bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       hi_rbuf_q <= '0;
        else if (lo_rd && ctrl_q.paired)  hi_rbuf_q <= cnt_q[CNT_W-1:BYTE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata);
            if (wrap)    ctrl_q.ovf <= 1'b1;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_LO:   bus_rdata = cnt_q[BYTE_W-1:0];
            ADDR_HI:   bus_rdata = ctrl_q.paired ? hi_rbuf_q
                                                 : cnt_q[CNT_W-1:BYTE_W];
            ADDR_CTRL: bus_rdata = ctrl_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign ctrl_o  = ctrl_q;
    assign count_o = cnt_q;

    // R11
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !load_o && cnt_q == '1) |=> (ctrl_q.ovf && cnt_q == '0));

    // R10
    low_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && !ctrl_q.paired) |=> (cnt_q[BYTE_W-1:0] == $past(bus_wdata)));

endmodule

// File: rtl/bytebus_timer.sv
module bytebus_timer
    import tmr_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_tick,
    input  logic       ext_clk,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_flag
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] count;
    logic             ext_tick, src_tick, inc_en, load;

    tmr_edge_fsm #(.SYNC_DEPTH(SYNC_DEPTH)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (ext_clk),
        .use_sync  (ctrl.sync),
        .edge_tick (ext_tick)
    );

    assign src_tick = ctrl.run && (ctrl.src_ext ? ext_tick : cyc_tick);

    tmr_prescale #(.SEL_W(2)) u_ps (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_in  (src_tick),
        .clear    (load),
        .sel      (ctrl.div_sel),
        .tick_out (inc_en)
    );

    tmr_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (reg_addr),
        .bus_wr    (reg_wr),
        .bus_rd    (reg_rd),
        .bus_wdata (reg_wdata),
        .inc_en    (inc_en),
        .bus_rdata (reg_rdata),
        .ctrl_o    (ctrl),
        .count_o   (count),
        .load_o    (load)
    );

    assign irq_flag = ctrl.ovf;

    // R4
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.run && !(reg_wr && reg_addr != ADDR_CTRL)) |=> $stable(count));

    // R6
    coherent_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_LO && ctrl.paired) |=>
        (!(reg_rd && reg_addr == ADDR_HI && ctrl.paired) ||
         reg_rdata == $past(count[CNT_W-1:BYTE_W])));

endmodule

// File: tb/bytebus_timer_tb.sv
module bytebus_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_tick = 1'b0;
    logic       ext_clk = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bytebus_timer u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_clk(ext_clk),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_flag(irq_flag)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_cnt(input logic [15:0] v);
        bus_wr(2'd0, v[7:0]);
        bus_wr(2'd1, v[15:8]);
    endtask

    task automatic read_cnt(output logic [15:0] v);
        logic [7:0] lo, hi;
        bus_rd(2'd0, lo);
        bus_rd(2'd1, hi);
        v = {hi, lo};
    endtask

    task automatic pulse_ticks(input int n);
        @(negedge clk);
        cyc_tick = 1'b1;
        repeat (n) @(negedge clk);
        cyc_tick = 1'b0;
    endtask

    task automatic ext_edge();
        @(negedge clk);
        ext_clk = 1'b1;
        repeat (4) @(negedge clk);
        ext_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        logic [15:0] v;
        bus_rd(2'd2, d);
        chk("R1 ctrl", {8'd0, d}, 16'h0000);
        read_cnt(v);
        chk("R1 count", v, 16'h0000);
        chk("R1 irq", {15'd0, irq_flag}, 16'h0000);
    endtask

    task automatic t_internal();
        logic [15:0] v;
        bus_wr(2'd2, 8'h01);
        pulse_ticks(5);
        read_cnt(v);
        chk("R2 five ticks", v, 16'h0005);
        for (int i = 0; i < 3; i++) begin
            pulse_ticks(1);
            @(negedge clk);
        end
        read_cnt(v);
        chk("R2 gapped ticks", v, 16'h0008);
    endtask

    task automatic t_prescale();
        logic [15:0] v;
        bus_wr(2'd2, 8'h09);
        set_cnt(16'h0000);
        pulse_ticks(8);
        read_cnt(v);
        chk("R3 div2", v, 16'h0004);
        bus_wr(2'd2, 8'h11);
        set_cnt(16'h0000);
        pulse_ticks(8);
        read_cnt(v);
        chk("R3 div4", v, 16'h0002);
        bus_wr(2'd2, 8'h19);
        set_cnt(16'h0000);
        pulse_ticks(7);
        read_cnt(v);
        chk("R3 div8 seven", v, 16'h0000);
        pulse_ticks(1);
        read_cnt(v);
        chk("R3 div8 eighth", v, 16'h0001);
    endtask

    task automatic t_run_off();
        logic [15:0] v;
        bus_wr(2'd2, 8'h00);
        set_cnt(16'h0042);
        pulse_ticks(10);
        ext_edge();
        read_cnt(v);
        chk("R4 held", v, 16'h0042);
    endtask

    task automatic t_ext_latency(input logic sync_on);
        logic [7:0] d;
        bus_wr(2'd2, 8'h00);
        set_cnt(16'h0000);
        bus_wr(2'd2, sync_on ? 8'h07 : 8'h03);
        repeat (4) @(negedge clk);
        ext_clk = 1'b1;
        @(negedge clk);
        peek(2'd0, d);
        chk("R5 not before 2nd edge", {8'd0, d}, 16'h0000);
        @(negedge clk);
        peek(2'd0, d);
        chk("R5 2nd edge", {8'd0, d}, sync_on ? 16'h0000 : 16'h0001);
        @(negedge clk);
        peek(2'd0, d);
        chk("R5 3rd edge", {8'd0, d}, 16'h0001);
        repeat (3) @(negedge clk);
        ext_clk = 1'b0;
        repeat (4) @(negedge clk);
        ext_edge();
        peek(2'd0, d);
        chk("R5 second pin edge", {8'd0, d}, 16'h0002);
    endtask

    task automatic t_paired_read();
        logic [7:0] d;
        bus_wr(2'd2, 8'h00);
        set_cnt(16'h12FF);
        bus_wr(2'd2, 8'h41);
        bus_rd(2'd0, d);
        chk("R6 low", {8'd0, d}, 16'h00FF);
        pulse_ticks(1);
        bus_rd(2'd1, d);
        chk("R6 held high", {8'd0, d}, 16'h0012);
        bus_wr(2'd2, 8'h01);
        bus_rd(2'd1, d);
        chk("R7 live high", {8'd0, d}, 16'h0013);
    endtask

    task automatic t_paired_ext(input logic sync_on, input logic [7:0] hi);
        logic [7:0] d;
        bus_wr(2'd2, 8'h00);
        set_cnt({hi, 8'hFF});
        bus_wr(2'd2, sync_on ? 8'h47 : 8'h43);
        bus_rd(2'd0, d);
        ext_edge();
        bus_rd(2'd1, d);
        chk(sync_on ? "R8 sync held" : "R8 unsync held", {8'd0, d}, {8'd0, hi});
        bus_rd(2'd0, d);
        chk("R8 low after edge", {8'd0, d}, 16'h0000);
        bus_rd(2'd1, d);
        chk(sync_on ? "R8 sync new" : "R8 unsync new", {8'd0, d}, {8'd0, hi + 8'd1});
    endtask

    task automatic t_writes();
        logic [15:0] v;
        logic [7:0] d;
        bus_wr(2'd2, 8'h00);
        set_cnt(16'h2211);
        bus_wr(2'd2, 8'h40);
        bus_wr(2'd1, 8'hAB);
        bus_wr(2'd2, 8'h00);
        read_cnt(v);
        chk("R9 high write deferred", v, 16'h2211);
        bus_wr(2'd2, 8'h40);
        bus_wr(2'd0, 8'hCD);
        bus_wr(2'd2, 8'h00);
        read_cnt(v);
        chk("R9 paired load", v, 16'hABCD);
        bus_wr(2'd1, 8'h5A);
        read_cnt(v);
        chk("R10 direct high", v, 16'h5ACD);
        bus_wr(2'd0, 8'h3C);
        bus_rd(2'd0, d);
        chk("R10 direct low", {8'd0, d}, 16'h003C);
    endtask

    task automatic t_overflow();
        logic [7:0] d;
        logic [15:0] v;
        bus_wr(2'd2, 8'h00);
        set_cnt(16'hFFFE);
        bus_wr(2'd2, 8'h01);
        pulse_ticks(1);
        chk("R11 no flag at FFFF", {15'd0, irq_flag}, 16'h0000);
        pulse_ticks(1);
        chk("R11 irq on wrap", {15'd0, irq_flag}, 16'h0001);
        bus_rd(2'd2, d);
        chk("R11 ctrl bit7", {8'd0, d}, 16'h0081);
        read_cnt(v);
        chk("R11 wrapped count", v, 16'h0000);
        pulse_ticks(3);
        chk("R11 sticky", {15'd0, irq_flag}, 16'h0001);
        bus_wr(2'd2, 8'h01);
        chk("R11 cleared", {15'd0, irq_flag}, 16'h0000);
        bus_wr(2'd2, 8'h00);
        set_cnt(16'hFFFF);
        bus_wr(2'd2, 8'h81);
        @(negedge clk);
        reg_addr = 2'd2; reg_wdata = 8'h01; reg_wr = 1'b1; cyc_tick = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; cyc_tick = 1'b0;
        chk("R11 wrap beats clear", {15'd0, irq_flag}, 16'h0001);
        bus_wr(2'd2, 8'h00);
    endtask

    task automatic t_priority();
        logic [7:0] d;
        bus_wr(2'd2, 8'h00);
        set_cnt(16'h0010);
        bus_wr(2'd2, 8'h01);
        @(negedge clk);
        reg_addr = 2'd0; reg_wdata = 8'h40; reg_wr = 1'b1; cyc_tick = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; cyc_tick = 1'b0;
        bus_rd(2'd0, d);
        chk("R12 write wins", {8'd0, d}, 16'h0040);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_internal();
        t_prescale();
        t_run_off();
        t_ext_latency(1'b0);
        t_ext_latency(1'b1);
        t_paired_read();
        t_paired_ext(1'b0, 8'h20);
        t_paired_ext(1'b1, 8'h30);
        t_writes();
        t_overflow();
        t_priority();
        finish_run();
    end
endmodule